// File: doc/BRIEF.md
# Four-Channel Analog Output Register Bank with Deferred Update

This block sits between a host register bus and four analog output converters, labelled channels 0 to 3. The host writes a 12-bit code for each channel and a shared range word that holds one bipolar-select bit and one high-gain bit per channel. These writes land in shadow registers. Values reach the converter-facing buses only at defined commit points, so the host can stage a complete new setting and apply it as one change.

A host *read* strobe commits staged values, and there are two commit addresses. Reading the range address moves the staged range word to the active range outputs. Reading the mode address moves all four staged codes to the active code outputs in a single cycle. A separate mode register has two bits. One enables the converters. The other selects buffered operation. With buffering off, a code write reaches its channel output directly and no commit read is needed.

A three-state update sequencer runs the commits. In `SEQ_IDLE` no commit is pending. A commit read taken while the converters are enabled moves it to `SEQ_LOAD_RANGE` (read of the range address) or `SEQ_LOAD_DATA` (read of the mode address). In the cycle after that, the active registers load. From either load state the sequencer goes to the load state that matches a new commit read in that cycle. Otherwise it returns to `SEQ_IDLE`. With the converters disabled, the sequencer stays in `SEQ_IDLE`.

Top module: `dacbank_top`

## Requirements
- R1: After reset every code output, every bipolar output and every gain output is zero, and the converters are disabled.
- R2: A write to byte address 0x14 + 2·k stores bits 11:0 of the write data as the staged code of channel k (k = 0..3). Bits 15:12 are discarded.
- R3: When buffered mode is on, a code write leaves the code outputs unchanged. A read of address 0x02 copies all four staged codes to the outputs together, and they appear two clock edges after the edge that samples the read.
- R4: A write to address 0x12 stages the range word: bit 7−k is the bipolar select of channel k and bit 11−k is its high-gain select. A read of address 0x12 copies the staged word to the range outputs two edges after the read, and the range outputs change at no other time while enabled.
- R5: A read of 0x12 leaves the code outputs unchanged, and a read of 0x02 leaves the range outputs unchanged.
- R6: When buffered mode is off, a code write to channel k appears on that channel's output at the same edge that samples the write.
- R7: While the converters are disabled, all code and range outputs read zero. Code writes and commit reads made during that time do not change the active values. When the converters are enabled again, the values that were active before the disable reappear.
- R8: A write to address 0x02 sets the converter enable from bit 1 and buffered mode from bit 0, and both take effect at the edge that samples the write.
- R9: Writing zero to 0x12 and then reading 0x12 returns every channel to unipolar operation at the default gain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (8) | Host byte address |
| bus_wr | input | 1 | Host write strobe, one cycle per write |
| bus_wdata | input | BUS_W (16) | Host write data |
| bus_rd | input | 1 | Host read strobe; used as a commit trigger |
| dac_code | output | NUM_CH·DATA_W (48) | Active codes, channel k in bits k·12 +: 12 |
| dac_bipolar | output | NUM_CH (4) | Active bipolar select, bit k for channel k |
| dac_gain_hi | output | NUM_CH (4) | Active high-gain select, bit k for channel k |

## Verification
Results arrive at three different latencies. A mode write, and a code write with buffering off, are visible right after the edge that samples them. A commit read shows nothing after its sampling edge, because the sequencer is in its load state, and the result appears after the second edge. The bench drives every access starting at a falling edge and reads the outputs at falling edges. It samples once after the first edge to confirm that nothing has moved yet, and again after the second edge to see the committed value. Disable and re-enable checks are read right after the mode write, because the gating on the outputs is combinational.

// File: rtl/dacbank_pkg.sv
`timescale 1ns/1ps
package dacbank_pkg;

    // Byte addresses; the mode address doubles as the code-commit read address,
    // the range address doubles as the range-commit read address.
    localparam logic [7:0] ADDR_MODE   = 8'h02;
    localparam logic [7:0] ADDR_RANGE  = 8'h12;
    localparam logic [7:0] ADDR_CODE0  = 8'h14;
    localparam int unsigned ADDR_STEP  = 2;

    // Bit positions inside the mode word
    localparam int unsigned MODE_EN_BIT  = 1;
    localparam int unsigned MODE_BUF_BIT = 0;

    // Range word: channel k uses bit (MSB - k)
    localparam int unsigned BIP_MSB  = 7;
    localparam int unsigned GAIN_MSB = 11;

    typedef enum logic [1:0] {
        SEQ_IDLE       = 2'd0,
        SEQ_LOAD_RANGE = 2'd1,
        SEQ_LOAD_DATA  = 2'd2
    } seq_state_e;

endpackage

// File: rtl/dacbank_decode.sv
`timescale 1ns/1ps
module dacbank_decode
    import dacbank_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output logic              wr_mode,
    output logic              wr_range,
    output logic [NUM_CH-1:0] wr_code,
    output logic              rd_commit_range,
    output logic              rd_commit_data
);

    localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(ADDR_MODE);
    localparam logic [ADDR_W-1:0] A_RANGE = ADDR_W'(ADDR_RANGE);

    assign wr_mode         = wr && (addr == A_MODE);
    assign wr_range        = wr && (addr == A_RANGE);
    assign rd_commit_data  = rd && (addr == A_MODE);
    assign rd_commit_range = rd && (addr == A_RANGE);

    generate
        for (genvar k = 0; k < NUM_CH; k++) begin : g_code_dec
            localparam logic [ADDR_W-1:0] A_CODE =
                ADDR_W'(int'(ADDR_CODE0) + int'(ADDR_STEP) * k);
            assign wr_code[k] = wr && (addr == A_CODE);
        end
    endgenerate

endmodule

// File: rtl/dacbank_shadow.sv
`timescale 1ns/1ps
module dacbank_shadow
    import dacbank_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned DATA_W = 12,
    parameter int unsigned BUS_W  = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [BUS_W-1:0]               wdata,
    input  logic                           wr_mode,
    input  logic                           wr_range,
    input  logic [NUM_CH-1:0]              wr_code,
    output logic                           mode_en,
    output logic                           mode_buf,
    output logic [NUM_CH-1:0]              stg_bip,
    output logic [NUM_CH-1:0]              stg_gain,
    output logic [NUM_CH-1:0][DATA_W-1:0]  stg_code
);

    logic unused_wdata_hi;
    assign unused_wdata_hi = ^wdata[BUS_W-1:GAIN_MSB+1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_en  <= 1'b0;
            mode_buf <= 1'b0;
        end else if (wr_mode) begin
            mode_en  <= wdata[MODE_EN_BIT];
            mode_buf <= wdata[MODE_BUF_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_bip  <= '0;
            stg_gain <= '0;
        end else if (wr_range) begin
            for (int k = 0; k < NUM_CH; k++) begin
                stg_bip[k]  <= wdata[BIP_MSB - k];
                stg_gain[k] <= wdata[GAIN_MSB - k];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_code <= '0;
        end else begin
            for (int k = 0; k < NUM_CH; k++) begin
                if (wr_code[k]) stg_code[k] <= wdata[DATA_W-1:0];
            end
        end
    end

endmodule

// File: rtl/dacbank_seq.sv
`timescale 1ns/1ps
module dacbank_seq
    import dacbank_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       rd_commit_range,
    input  logic       rd_commit_data,
    output logic       load_range,
    output logic       load_data,
    output seq_state_e state
);

    seq_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = SEQ_IDLE;
        unique case (state_q)
            SEQ_IDLE, SEQ_LOAD_RANGE, SEQ_LOAD_DATA: begin
                if (!en)                  state_d = SEQ_IDLE;
                else if (rd_commit_range) state_d = SEQ_LOAD_RANGE;
                else if (rd_commit_data)  state_d = SEQ_LOAD_DATA;
                else                      state_d = SEQ_IDLE;
            end
            default: state_d = SEQ_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        load_range = 1'b0;
        load_data  = 1'b0;
        unique case (state_q)
            SEQ_IDLE:       ;
            SEQ_LOAD_RANGE: load_range = 1'b1;
            SEQ_LOAD_DATA:  load_data  = 1'b1;
            default:        ;
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/dacbank_active.sv
`timescale 1ns/1ps
module dacbank_active #(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned DATA_W = 12
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           en,
    input  logic                           buffered,
    input  logic                           load_range,
    input  logic                           load_data,
    input  logic [NUM_CH-1:0]              wr_code,
    input  logic [DATA_W-1:0]              wdata_lo,
    input  logic [NUM_CH-1:0]              stg_bip,
    input  logic [NUM_CH-1:0]              stg_gain,
    input  logic [NUM_CH-1:0][DATA_W-1:0]  stg_code,
    output logic [NUM_CH*DATA_W-1:0]       dac_code,
    output logic [NUM_CH-1:0]              dac_bipolar,
    output logic [NUM_CH-1:0]              dac_gain_hi
);

    logic [NUM_CH-1:0]             act_bip, act_gain;
    logic [NUM_CH-1:0][DATA_W-1:0] act_code;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_bip  <= '0;
            act_gain <= '0;
        end else if (en && load_range) begin
            act_bip  <= stg_bip;
            act_gain <= stg_gain;
        end
    end

    // Direct write (unbuffered) takes priority over a commit in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_code <= '0;
        end else if (en) begin
            for (int k = 0; k < NUM_CH; k++) begin
                if (!buffered && wr_code[k]) act_code[k] <= wdata_lo;
                else if (load_data)          act_code[k] <= stg_code[k];
            end
        end
    end

    generate
        for (genvar k = 0; k < NUM_CH; k++) begin : g_out
            assign dac_code[k*DATA_W +: DATA_W] = en ? act_code[k] : '0;
        end
    endgenerate

    assign dac_bipolar = en ? act_bip  : '0;
    assign dac_gain_hi = en ? act_gain : '0;

endmodule

// File: rtl/dacbank_top.sv
`timescale 1ns/1ps
module dacbank_top
    import dacbank_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned DATA_W = 12,
    parameter int unsigned BUS_W  = 16,
    parameter int unsigned ADDR_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic                     bus_wr,
    input  logic [BUS_W-1:0]         bus_wdata,
    input  logic                     bus_rd,
    output logic [NUM_CH*DATA_W-1:0] dac_code,
    output logic [NUM_CH-1:0]        dac_bipolar,
    output logic [NUM_CH-1:0]        dac_gain_hi
);

    logic                          wr_mode, wr_range;
    logic [NUM_CH-1:0]             wr_code;
    logic                          rd_commit_range, rd_commit_data;
    logic                          ctl_en, ctl_buf;
    logic [NUM_CH-1:0]             stg_bip, stg_gain;
    logic [NUM_CH-1:0][DATA_W-1:0] stg_code;
    logic                          load_range, load_data;
    seq_state_e                    seq_state;

    dacbank_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) decode_i (
        .addr            (bus_addr),
        .wr              (bus_wr),
        .rd              (bus_rd),
        .wr_mode         (wr_mode),
        .wr_range        (wr_range),
        .wr_code         (wr_code),
        .rd_commit_range (rd_commit_range),
        .rd_commit_data  (rd_commit_data)
    );

    dacbank_shadow #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .BUS_W(BUS_W)) shadow_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wdata    (bus_wdata),
        .wr_mode  (wr_mode),
        .wr_range (wr_range),
        .wr_code  (wr_code),
        .mode_en  (ctl_en),
        .mode_buf (ctl_buf),
        .stg_bip  (stg_bip),
        .stg_gain (stg_gain),
        .stg_code (stg_code)
    );

    dacbank_seq seq_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .en              (ctl_en),
        .rd_commit_range (rd_commit_range),
        .rd_commit_data  (rd_commit_data),
        .load_range      (load_range),
        .load_data       (load_data),
        .state           (seq_state)
    );

    dacbank_active #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) active_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (ctl_en),
        .buffered    (ctl_buf),
        .load_range  (load_range),
        .load_data   (load_data),
        .wr_code     (wr_code),
        .wdata_lo    (bus_wdata[DATA_W-1:0]),
        .stg_bip     (stg_bip),
        .stg_gain    (stg_gain),
        .stg_code    (stg_code),
        .dac_code    (dac_code),
        .dac_bipolar (dac_bipolar),
        .dac_gain_hi (dac_gain_hi)
    );

endmodule

// File: rtl/dacbank_chk.sv
`timescale 1ns/1ps
module dacbank_chk
    import dacbank_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned DATA_W = 12,
    parameter int unsigned BUS_W  = 16,
    parameter int unsigned ADDR_W = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [ADDR_W-1:0]        bus_addr,
    input logic                     bus_wr,
    input logic                     bus_rd,
    input logic [BUS_W-1:0]         bus_wdata,
    input logic [NUM_CH*DATA_W-1:0] dac_code,
    input logic [NUM_CH-1:0]        dac_bipolar,
    input logic [NUM_CH-1:0]        dac_gain_hi,
    input logic                     ctl_en,
    input logic                     ctl_buf,
    input seq_state_e               seq_state
);

    localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(ADDR_MODE);
    localparam logic [ADDR_W-1:0] A_RANGE = ADDR_W'(ADDR_RANGE);
    localparam logic [ADDR_W-1:0] A_CODE0 = ADDR_W'(ADDR_CODE0);

    assert_range_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctl_en) && ctl_en && $past(seq_state) != SEQ_LOAD_RANGE)
        |-> ($stable(dac_bipolar) && $stable(dac_gain_hi)));

    assert_code_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctl_en) && ctl_en && $past(ctl_buf) && $past(seq_state) != SEQ_LOAD_DATA)
        |-> $stable(dac_code));

    assert_enter_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bus_rd) && $past(bus_addr) == A_MODE && $past(ctl_en))
        |-> seq_state == SEQ_LOAD_DATA);

    assert_enter_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bus_rd) && $past(bus_addr) == A_RANGE && $past(ctl_en))
        |-> seq_state == SEQ_LOAD_RANGE);

    assert_direct_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctl_en) && !$past(ctl_buf) && $past(bus_wr) && !$past(bus_rd)
         && $past(bus_addr) == A_CODE0 && ctl_en)
        |-> dac_code[DATA_W-1:0] == $past(bus_wdata[DATA_W-1:0]));

    assert_idle_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state != SEQ_IDLE) |-> $past(ctl_en));

endmodule

bind dacbank_top dacbank_chk #(
    .NUM_CH(NUM_CH), .DATA_W(DATA_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_wdata   (bus_wdata),
    .dac_code    (dac_code),
    .dac_bipolar (dac_bipolar),
    .dac_gain_hi (dac_gain_hi),
    .ctl_en      (ctl_en),
    .ctl_buf     (ctl_buf),
    .seq_state   (seq_state)
);

// File: tb/dacbank_top_tb_top.sv
`timescale 1ns/1ps
module dacbank_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [47:0] dac_code;
    logic [3:0]  dac_bipolar;
    logic [3:0]  dac_gain_hi;

    int n_checks = 0;
    int n_bad    = 0;

    always #2 clk = ~clk;

    dacbank_top dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_wr      (bus_wr),
        .bus_wdata   (bus_wdata),
        .bus_rd      (bus_rd),
        .dac_code    (dac_code),
        .dac_bipolar (dac_bipolar),
        .dac_gain_hi (dac_gain_hi)
    );

    task automatic check(input string req, input string what,
                         input logic [47:0] act, input logic [47:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [47:0] codes(input logic [11:0] c0, input logic [11:0] c1,
                                          input logic [11:0] c2, input logic [11:0] c3);
        return {c3, c2, c1, c0};
    endfunction

    task automatic bus_write(input logic [7:0] a, input logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [7:0] a);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic t_reset();
        check("R1", "codes after reset", dac_code, '0);
        check("R1", "bipolar after reset", {44'd0, dac_bipolar}, '0);
        check("R1", "gain after reset", {44'd0, dac_gain_hi}, '0);
    endtask

    task automatic t_unbuffered();
        bus_write(8'h02, 16'h0002);            // R8: enable, unbuffered
        bus_write(8'h14, 16'h0ABC);            // R6
        check("R6", "ch0 direct", dac_code, codes(12'hABC, 0, 0, 0));
        bus_write(8'h18, 16'hF123);            // R2 upper bits dropped
        check("R2", "ch2 direct masked", dac_code, codes(12'hABC, 0, 12'h123, 0));
    endtask

    task automatic t_buffered();
        bus_write(8'h02, 16'h0003);            // R8: enable, buffered
        bus_write(8'h16, 16'h0555);
        bus_write(8'h1A, 16'hF7FF);
        check("R3", "codes held while staged", dac_code, codes(12'hABC, 0, 12'h123, 0));
        bus_read(8'h02);
        check("R3", "codes one edge after commit", dac_code, codes(12'hABC, 0, 12'h123, 0));
        @(negedge clk);
        check("R3", "codes two edges after commit", dac_code,
              codes(12'hABC, 12'h555, 12'h123, 12'h7FF));
    endtask

    task automatic t_range();
        bus_write(8'h12, 16'h0290);            // R4: bip ch0, bip ch3, gain ch2
        check("R4", "bipolar before commit", {44'd0, dac_bipolar}, '0);
        bus_read(8'h02);
        @(negedge clk);
        check("R5", "bipolar after code commit", {44'd0, dac_bipolar}, '0);
        bus_read(8'h12);
        check("R4", "gain one edge after commit", {44'd0, dac_gain_hi}, '0);
        @(negedge clk);
        check("R4", "bipolar committed", {44'd0, dac_bipolar}, 48'h9);
        check("R4", "gain committed", {44'd0, dac_gain_hi}, 48'h4);
        bus_write(8'h14, 16'h0111);
        bus_read(8'h12);
        @(negedge clk);
        check("R5", "codes after range commit", dac_code,
              codes(12'hABC, 12'h555, 12'h123, 12'h7FF));
        bus_read(8'h02);
        @(negedge clk);
        check("R5", "codes after code commit", dac_code,
              codes(12'h111, 12'h555, 12'h123, 12'h7FF));
    endtask

    task automatic t_disable();
        bus_write(8'h02, 16'h0001);            // disabled, buffered
        check("R7", "codes zero when off", dac_code, '0);
        check("R7", "bipolar zero when off", {44'd0, dac_bipolar}, '0);
        bus_write(8'h16, 16'h0222);
        bus_write(8'h12, 16'h0000);
        bus_read(8'h02);
        @(negedge clk);
        bus_read(8'h12);
        @(negedge clk);
        check("R7", "codes still zero when off", dac_code, '0);
        bus_write(8'h02, 16'h0003);            // re-enable
        check("R7", "codes held across disable", dac_code,
              codes(12'h111, 12'h555, 12'h123, 12'h7FF));
        check("R7", "bipolar held across disable", {44'd0, dac_bipolar}, 48'h9);
        bus_read(8'h02);
        @(negedge clk);
        check("R3", "staged code applied after enable", dac_code,
              codes(12'h111, 12'h222, 12'h123, 12'h7FF));
    endtask

    task automatic t_clear();
        bus_write(8'h12, 16'h0000);
        bus_read(8'h12);
        @(negedge clk);
        check("R9", "bipolar cleared", {44'd0, dac_bipolar}, '0);
        check("R9", "gain cleared", {44'd0, dac_gain_hi}, '0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unbuffered();
        t_buffered();
        t_range();
        t_disable();
        t_clear();
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        #40000;
        n_checks++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

endmodule